// File: doc/BRIEF.md
# Accumulator Memory-Reference Control Sequencer

This block is the hardwired control path of a small 16-bit accumulator processor, together with the datapath registers it drives and a word-addressed program/data store. A timing-state counter steps through numbered states, and the opcode of the current instruction is latched as a one-hot decode vector. In each state the block applies the register transfers for that opcode. These cover the instruction fetch, the decode, an optional indirect address lookup, and the execute steps of seven memory-reference operations. The operations are bitwise AND, add with carry into a link bit, load, store, jump, subroutine call with return-address save, and increment-and-skip-if-zero.

An instruction word carries a 12-bit address in bits 11:0, an opcode in bits 14:12 and an indirect flag in bit 15. Opcode values 0 to 6 select AND, ADD, LDA, STA, BUN, BSA and ISZ in that order. Opcode 7 is a no-op. A program is loaded through a preload write port while the `halt` input is high. Dropping `halt` then lets the sequencer run from the reset program counter. The accumulator, program counter, link bit and timing state are visible on outputs.

Top module: `acc_mref_ctrl`

## Requirements
- R1: While `rst_n` is low, the timing state, accumulator and link bit read 0 and the program counter reads `START_PC` (0 by default).
- R2: Every instruction begins with a fetch: state 0 copies PC to the address register, and state 1 loads the instruction register from memory and increments PC by one.
- R3: When bit 15 of the instruction is 1 and the opcode is 0 to 6, state 3 replaces the address register with the low address bits of the word at that address. Otherwise state 3 changes no register.
- R4: Opcode 0 (AND) reads the operand into the data register in state 4, and in state 5 sets AC to AC bitwise-AND operand.
- R5: Opcode 1 (ADD) sets AC to the low 16 bits of AC + operand, and sets the link bit to the carry out of bit 15. No other opcode changes the link bit.
- R6: Opcode 2 (LDA) passes the operand through the data register and loads it into AC in state 5.
- R7: Opcode 3 (STA) writes AC to the effective address in state 4.
- R8: Opcode 4 (BUN) loads PC with the effective address in state 4.
- R9: Opcode 5 (BSA) stores the zero-extended PC at the effective address in state 4 and increments the address register. In state 5 it loads PC from the address register, so execution continues at the effective address + 1.
- R10: Opcode 6 (ISZ) reads the operand in state 4 and increments it in state 5. In state 6 it writes the result back, and if that result is zero it increments PC once more, which skips the next instruction.
- R11: Opcode 7 is a no-op that ends at state 3, whatever the indirect flag is.
- R12: While `halt` is high the timing state, AC, PC and link bit hold their values, and only then does the preload port write memory.
- R13: The last step of each instruction returns the state to 0. An instruction therefore takes 4 clock cycles for the no-op, 5 for STA and BUN, 6 for AND, ADD, LDA and BSA, and 7 for ISZ, and the state never reaches 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Freezes sequencing and enables preload writes |
| pl_we | input | 1 | Preload write strobe (used only while halted) |
| pl_addr | input | MEM_AW (10) | Preload word address |
| pl_data | input | DW (16) | Preload word data |
| ac_o | output | DW (16) | Accumulator |
| pc_o | output | ADDR_W (12) | Program counter |
| e_o | output | 1 | Link (carry) bit |
| sc_o | output | SC_W (3) | Current timing state |

## Verification
The assertions assume that `halt` and the preload signals change only between clock edges, and that a preload write never arrives while the sequencer is running. They also assume that the program never tries to fetch from an address outside the store. The stimulus loads every word with `halt` high, releases it on a falling edge, and lays the program and its data inside the low kilo-word. It guards the single skipped word with a load that would visibly corrupt AC if the skip failed. Halting is exercised only mid-instruction and at falling edges, so the frozen state is always a legal one.

// File: rtl/acc_mref_pkg.sv
package acc_mref_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0,
    OP_ADD = 3'd1,
    OP_LDA = 3'd2,
    OP_STA = 3'd3,
    OP_BUN = 3'd4,
    OP_BSA = 3'd5,
    OP_ISZ = 3'd6,
    OP_NOP = 3'd7
  } op_e;

  localparam int NUM_OPS = 1 << OP_W;
endpackage

// File: rtl/step_counter.sv
module step_counter #(
  parameter int SC_W = 3,
  localparam int NST = 1 << SC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr,
  output logic [SC_W-1:0] sc_q,
  output logic [NST-1:0]  t_o
);
  logic [SC_W-1:0] sc_d;

  always_comb begin
    sc_d = clr ? '0 : sc_q + SC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sc_q <= '0;
    else if (en) sc_q <= sc_d;
  end

  for (genvar g = 0; g < NST; g++) begin : g_tline
    assign t_o[g] = (sc_q == SC_W'(g));
  end

  // R12: a halted sequencer keeps its state
  p_freeze_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sc_q));
  // R13: a clear returns control to state 0
  p_clear_to_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    en && clr |=> sc_q == '0);
endmodule

// File: rtl/op_decoder.sv
module op_decoder
  import acc_mref_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [OP_W-1:0]    op,
  output logic [NUM_OPS-1:0] d_q
);
  logic [NUM_OPS-1:0] d_d;

  always_comb begin
    d_d = '0;
    d_d[op] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    d_q <= '0;
    else if (load) d_q <= d_d;
  end

  // R2: at most one decode line is active
  p_decode_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(d_q));
  p_decode_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> d_q[$past(op)] && $countones(d_q) == 1);
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int AW = 10,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/acc_mref_ctrl.sv
module acc_mref_ctrl
  import acc_mref_pkg::*;
#(
  parameter int DW       = 16,
  parameter int ADDR_W   = 12,
  parameter int MEM_AW   = 10,
  parameter int SC_W     = 3,
  parameter logic [ADDR_W-1:0] START_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              pl_we,
  input  logic [MEM_AW-1:0] pl_addr,
  input  logic [DW-1:0]     pl_data,
  output logic [DW-1:0]     ac_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              e_o,
  output logic [SC_W-1:0]   sc_o
);
  localparam int NST   = 1 << SC_W;
  localparam int IND_B = DW - 1;
  localparam int OP_LO = ADDR_W;

  logic              run;
  logic [SC_W-1:0]   sc_q;
  logic [NST-1:0]    t;
  logic [NUM_OPS-1:0] d;
  logic              sc_clr, dec_ld;

  logic [ADDR_W-1:0] ar_q, ar_d, pc_q, pc_d;
  logic [DW-1:0]     dr_q, dr_d, ac_q, ac_d, ir_q, ir_d;
  logic              e_q, e_d, ind_q, ind_d;

  logic              x_we, m_we;
  logic [DW-1:0]     x_wd, m_wd, rd;
  logic [MEM_AW-1:0] m_wa;
  logic [DW:0]       sum;

  assign run = !halt;

  step_counter #(.SC_W(SC_W)) u_sc (
    .clk(clk), .rst_n(rst_n), .en(run), .clr(sc_clr), .sc_q(sc_q), .t_o(t)
  );

  op_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .load(run && dec_ld),
    .op(ir_q[OP_LO +: OP_W]), .d_q(d)
  );

  assign m_we = halt ? pl_we   : x_we;
  assign m_wa = halt ? pl_addr : ar_q[MEM_AW-1:0];
  assign m_wd = halt ? pl_data : x_wd;

  word_store #(.AW(MEM_AW), .DW(DW)) u_mem (
    .clk(clk), .we(m_we), .waddr(m_wa), .wdata(m_wd),
    .raddr(ar_q[MEM_AW-1:0]), .rdata(rd)
  );

  assign sum = {1'b0, ac_q} + {1'b0, dr_q};

  // next-state: micro-operations per timing state and decode line
  always_comb begin
    ar_d = ar_q; pc_d = pc_q; dr_d = dr_q; ac_d = ac_q;
    ir_d = ir_q; e_d = e_q; ind_d = ind_q;
    sc_clr = 1'b0; dec_ld = 1'b0; x_we = 1'b0; x_wd = '0;
    unique case (1'b1)
      t[0]: ar_d = pc_q;
      t[1]: begin ir_d = rd; pc_d = pc_q + ADDR_W'(1); end
      t[2]: begin
        ar_d = ir_q[ADDR_W-1:0]; ind_d = ir_q[IND_B]; dec_ld = 1'b1;
      end
      t[3]: begin
        if (d[OP_NOP])   sc_clr = 1'b1;
        else if (ind_q)  ar_d = rd[ADDR_W-1:0];
      end
      t[4]: begin
        if (d[OP_AND] || d[OP_ADD] || d[OP_LDA] || d[OP_ISZ]) dr_d = rd;
        if (d[OP_STA]) begin x_we = 1'b1; x_wd = ac_q; sc_clr = 1'b1; end
        if (d[OP_BUN]) begin pc_d = ar_q; sc_clr = 1'b1; end
        if (d[OP_BSA]) begin
          x_we = 1'b1; x_wd = DW'(pc_q); ar_d = ar_q + ADDR_W'(1);
        end
      end
      t[5]: begin
        if (d[OP_AND]) begin ac_d = ac_q & dr_q; sc_clr = 1'b1; end
        if (d[OP_ADD]) begin ac_d = sum[DW-1:0]; e_d = sum[DW]; sc_clr = 1'b1; end
        if (d[OP_LDA]) begin ac_d = dr_q; sc_clr = 1'b1; end
        if (d[OP_BSA]) begin pc_d = ar_q; sc_clr = 1'b1; end
        if (d[OP_ISZ]) dr_d = dr_q + DW'(1);
      end
      t[6]: begin
        if (d[OP_ISZ]) begin
          x_we = 1'b1; x_wd = dr_q; sc_clr = 1'b1;
          if (dr_q == '0) pc_d = pc_q + ADDR_W'(1);
        end
      end
      default: sc_clr = 1'b1;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q <= '0; pc_q <= START_PC; dr_q <= '0; ac_q <= '0;
      ir_q <= '0; e_q <= 1'b0; ind_q <= 1'b0;
    end else if (run) begin
      ar_q <= ar_d; pc_q <= pc_d; dr_q <= dr_d; ac_q <= ac_d;
      ir_q <= ir_d; e_q <= e_d; ind_q <= ind_d;
    end
  end

  assign ac_o = ac_q;
  assign pc_o = pc_q;
  assign e_o  = e_q;
  assign sc_o = sc_q;

  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && t[1] |=> pc_q == $past(pc_q) + ADDR_W'(1));
  p_halt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(ac_q) && $stable(pc_q) && $stable(e_q));
  p_nop_short_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run && t[3] && d[OP_NOP] |=> sc_q == '0);
  p_isz_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run && t[6] && d[OP_ISZ] && dr_q == '0 |=> pc_q == $past(pc_q) + ADDR_W'(1));
  p_bsa_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run && t[5] && d[OP_BSA] |=> pc_q == $past(ar_q));
  p_link_only_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run && !(t[5] && d[OP_ADD]) |=> $stable(e_q));
  p_state_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sc_q != '1);
endmodule

// File: tb/tb_acc_mref_ctrl.sv
module tb_acc_mref_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  localparam int ND = 8;

  typedef struct packed {
    logic [11:0] addr;
    logic [15:0] word;
    logic [3:0]  cyc;
    logic [15:0] ac;
    logic [11:0] pc;
    logic        e;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{12'h000, 16'h2101, 4'd6, 16'h0F3C, 12'h001, 1'b0, 4'd6},
    '{12'h001, 16'h0100, 4'd6, 16'h0030, 12'h002, 1'b0, 4'd4},
    '{12'h002, 16'h1102, 4'd6, 16'h002F, 12'h003, 1'b1, 4'd5},
    '{12'h003, 16'hA103, 4'd6, 16'h0F3C, 12'h004, 1'b1, 4'd3},
    '{12'h004, 16'h3105, 4'd5, 16'h0F3C, 12'h005, 1'b1, 4'd7},
    '{12'h005, 16'h6104, 4'd7, 16'h0F3C, 12'h006, 1'b1, 4'd10},
    '{12'h006, 16'h6104, 4'd7, 16'h0F3C, 12'h008, 1'b1, 4'd10},
    '{12'h008, 16'h7000, 4'd4, 16'h0F3C, 12'h009, 1'b1, 4'd11},
    '{12'h009, 16'h1100, 4'd6, 16'h102C, 12'h00A, 1'b0, 4'd5},
    '{12'h00A, 16'h5200, 4'd6, 16'h102C, 12'h201, 1'b0, 4'd9},
    '{12'h201, 16'h2105, 4'd6, 16'h0F3C, 12'h202, 1'b0, 4'd7},
    '{12'h202, 16'hC200, 4'd5, 16'h0F3C, 12'h00B, 1'b0, 4'd8},
    '{12'h00B, 16'h2200, 4'd6, 16'h000B, 12'h00C, 1'b0, 4'd9},
    '{12'h00C, 16'h4010, 4'd5, 16'h000B, 12'h010, 1'b0, 4'd8},
    '{12'h010, 16'h2104, 4'd6, 16'h0000, 12'h011, 1'b0, 4'd10},
    '{12'h011, 16'hF000, 4'd4, 16'h0000, 12'h012, 1'b0, 4'd11}
  };

  // extra words: operands, pointer, counter, trap and halt-test load
  localparam logic [27:0] DATA [ND] = '{
    {12'h100, 16'h00F0}, {12'h101, 16'h0F3C}, {12'h102, 16'hFFFF},
    {12'h103, 16'h0101}, {12'h104, 16'hFFFE}, {12'h200, 16'h0000},
    {12'h007, 16'h2102}, {12'h012, 16'h2100}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b1;
  logic        pl_we = 1'b0;
  logic [9:0]  pl_addr = '0;
  logic [15:0] pl_data = '0;
  logic [15:0] ac_o;
  logic [11:0] pc_o;
  logic        e_o;
  logic [2:0]  sc_o;

  int n_run = 0;
  int n_fail = 0;

  acc_mref_ctrl dut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .pl_we(pl_we),
    .pl_addr(pl_addr), .pl_data(pl_data),
    .ac_o(ac_o), .pc_o(pc_o), .e_o(e_o), .sc_o(sc_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic preload(input logic [11:0] a, input logic [15:0] w);
    pl_we = 1'b1; pl_addr = a[9:0]; pl_data = w;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "sc", 32'(sc_o), 32'd0);
    chk("R1", "ac", 32'(ac_o), 32'd0);
    chk("R1", "pc", 32'(pc_o), 32'd0);
    chk("R1", "e",  32'(e_o),  32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: preload only while halted; registers hold meanwhile
    for (int i = 0; i < NV; i++) preload(VEC[i].addr, VEC[i].word);
    for (int i = 0; i < ND; i++) preload(DATA[i][27:16], DATA[i][15:0]);
    chk("R12", "sc held", 32'(sc_o), 32'd0);
    chk("R12", "pc held", 32'(pc_o), 32'd0);

    halt = 1'b0;
    for (int i = 0; i < NV; i++) begin
      repeat (int'(VEC[i].cyc) - 1) @(negedge clk);
      chk("R13", "state before last step", 32'(sc_o), 32'(VEC[i].cyc) - 1);
      @(negedge clk);
      chk("R13", "state after last step", 32'(sc_o), 32'd0);
      chk(tag(VEC[i].req), "ac", 32'(ac_o), 32'(VEC[i].ac));
      chk(tag(VEC[i].req), "pc", 32'(pc_o), 32'(VEC[i].pc));
      chk(tag(VEC[i].req), "e",  32'(e_o),  32'(VEC[i].e));
    end

    // R2 and R12: halt in the middle of a load at 0x012
    repeat (2) @(negedge clk);
    chk("R2", "pc after fetch", 32'(pc_o), 32'h013);
    chk("R2", "state after fetch", 32'(sc_o), 32'd2);
    halt = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12", "sc frozen", 32'(sc_o), 32'd2);
    chk("R12", "pc frozen", 32'(pc_o), 32'h013);
    chk("R12", "ac frozen", 32'(ac_o), 32'h0000);
    halt = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6", "ac after resumed load", 32'(ac_o), 32'h00F0);
    chk("R13", "state after resumed load", 32'(sc_o), 32'd0);

    // R1: reset while running
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "sc in reset", 32'(sc_o), 32'd0);
    chk("R1", "pc in reset", 32'(pc_o), 32'd0);
    chk("R1", "ac in reset", 32'(ac_o), 32'd0);
    summary();
  end
endmodule